// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs management transactions against an external PHY over a two-wire serial link. It produces the MDC management clock by dividing the system clock. It drives the bidirectional MDIO line as an output value plus an output enable. An MDIO input returns the level seen on the line. The pad tristate buffer sits outside the block.

Software loads a control register and a 16-bit data register. The control register holds the PHY address, the register address, a write/read select and a start bit. Setting the start bit makes the block go busy. It then shifts out a 64-bit frame with the most significant bit first:

- a run of ones,
- the start pattern,
- an opcode,
- the two addresses,
- a turnaround,
- a 16-bit data field.

On a read, the block releases the line for the turnaround and data bits. It samples the data bits on MDC rising edges and loads the captured word into the data register when it finishes. While busy is high, register writes have no effect.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, mdc and mdio_oe are low, and phy_q, reg_q, write_q and data_q are all zero. While idle, mdc stays low and mdio_oe stays low.
- R2: A control write with ctl_start=1 while idle sets busy at that clock edge. After that edge mdc starts low and toggles every CLK_DIV clocks, so one MDC period, which is one bit time, lasts 2*CLK_DIV clocks.
- R3: Bit times 0 to 31 drive 1 with the output enable on.
- R4: Bit times 32 and 33 drive 0 then 1. Bit times 34 and 35 carry the opcode: 0,1 for a write (write_q=1) and 1,0 for a read (write_q=0).
- R5: Bit times 36 to 40 carry phy_q and bit times 41 to 45 carry reg_q, each most significant bit first.
- R6: On a write, bit times 46 and 47 drive 1 then 0, and bit times 48 to 63 drive data_q from bit 15 down to bit 0. The output enable stays on for the whole frame.
- R7: On a read, mdio_oe is low for bit times 46 to 63. mdio_i is sampled on the MDC rising edges of bit times 48 to 63, most significant bit first. The captured word appears in data_q at the same clock edge at which busy clears.
- R8: While driven, mdio_o changes only at a clock edge where mdc goes from high to low.
- R9: busy clears 128*CLK_DIV clocks after the edge that set it, at the falling edge of MDC that ends bit time 63. mdc is low from then on.
- R10: While busy is high, control writes (including ones with ctl_start=1) and data writes are ignored: phy_q, reg_q, write_q and data_q keep their values and the frame runs unchanged.
- R11: While idle, a control write with ctl_start=0 loads phy_q, reg_q and write_q without starting a frame. A data write loads data_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_phy | input | 5 | PHY address to load |
| ctl_reg | input | 5 | Register address to load |
| ctl_write | input | 1 | 1 selects write, 0 selects read |
| ctl_start | input | 1 | Start a transaction with this control write |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data register write value |
| phy_q | output | 5 | Held PHY address |
| reg_q | output | 5 | Held register address |
| write_q | output | 1 | Held write/read select |
| busy | output | 1 | Transaction in progress |
| data_q | output | 16 | Data register (write source, read result) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line level |

## Verification
The embedded properties assume reset is low for at least one clock before use. They also assume the held registers change only through the write strobes, so a value is stable across any two busy cycles. The stimulus never writes a register while a transaction runs except on purpose to probe R10. On those probes the bench model also expects the write to be dropped. The emulated PHY drives mdio_i from the bench's own bit-time count. It pulls the line high outside the read data window and drives 0 in the second turnaround bit. It changes only after a clock edge, so every sample the block takes sees a settled level.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [4:0]  ctl_phy,
  input  logic [4:0]  ctl_reg,
  input  logic        ctl_write,
  input  logic        ctl_start,
  input  logic        data_we,
  input  logic [15:0] data_wdata,
  output logic [4:0]  phy_q,
  output logic [4:0]  reg_q,
  output logic        write_q,
  output logic        busy,
  output logic [15:0] data_q,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] div_cnt;
  logic [5:0]    bit_idx;
  logic [15:0]   rx_sh;
  logic [63:0]   frame;
  logic          tick, rise, fall, in_rd_win, in_rx_win;

  assign tick      = busy && (div_cnt == DIV_LAST);
  assign rise      = tick && !mdc;
  assign fall      = tick && mdc;
  assign in_rd_win = !write_q && (bit_idx >= 6'd46);
  assign in_rx_win = !write_q && (bit_idx >= 6'd48);

  assign frame = {32'hFFFF_FFFF, 2'b01,
                  write_q ? 2'b01 : 2'b10,
                  phy_q, reg_q,
                  write_q ? 2'b10 : 2'b00,
                  write_q ? data_q : 16'h0000};

  assign mdio_oe = busy && !in_rd_win;
  assign mdio_o  = busy ? frame[6'd63 - bit_idx] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q   <= '0;
      reg_q   <= '0;
      write_q <= 1'b0;
      data_q  <= '0;
      busy    <= 1'b0;
      mdc     <= 1'b0;
      div_cnt <= '0;
      bit_idx <= '0;
      rx_sh   <= '0;
    end else if (!busy) begin
      if (data_we) data_q <= data_wdata;
      if (ctl_we) begin
        phy_q   <= ctl_phy;
        reg_q   <= ctl_reg;
        write_q <= ctl_write;
        if (ctl_start) begin
          busy    <= 1'b1;
          mdc     <= 1'b0;
          div_cnt <= '0;
          bit_idx <= '0;
        end
      end
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (rise) begin
        mdc <= 1'b1;
        if (in_rx_win) rx_sh <= {rx_sh[14:0], mdio_i};
      end
      if (fall) begin
        mdc <= 1'b0;
        if (bit_idx == 6'd63) begin
          busy <= 1'b0;
          if (!write_q) data_q <= rx_sh;
        end else begin
          bit_idx <= bit_idx + 6'd1;
        end
      end
    end
  end

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R1

  AST_PREAMBLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bit_idx < 6'd32 |-> mdio_oe && mdio_o); // R3

  AST_WR_TA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && write_q && bit_idx == 6'd47 |-> mdio_oe && !mdio_o); // R6

  AST_RD_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !write_q |-> $stable(data_q)); // R7

  AST_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))
    |-> !mdc && $past(mdc)); // R8

  AST_DONE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !mdc); // R9

  AST_FIELDS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(phy_q) && $stable(reg_q) && $stable(write_q)); // R10

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int D = 2;
  localparam int FRAME_CLKS = 128 * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, ctl_write = 1'b0, ctl_start = 1'b0, data_we = 1'b0;
  logic [4:0] ctl_phy = '0, ctl_reg = '0;
  logic [15:0] data_wdata = '0;
  logic [4:0] phy_q, reg_q;
  logic write_q, busy, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] data_q;

  always #4 clk = ~clk;

  mdio_master #(.CLK_DIV(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_phy(ctl_phy), .ctl_reg(ctl_reg),
    .ctl_write(ctl_write), .ctl_start(ctl_start), .data_we(data_we),
    .data_wdata(data_wdata), .phy_q(phy_q), .reg_q(reg_q), .write_q(write_q),
    .busy(busy), .data_q(data_q), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  // reference model state
  logic        m_busy = 1'b0, m_wr = 1'b0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic [15:0] m_data = '0;
  logic [15:0] phy_word = 16'h0000;
  int          m_t = 0;
  int          checks = 0, fails = 0;
  bit          done = 0;
  logic        prev_o = 1'b1, prev_oe = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_wr <= 1'b0; m_phy <= '0; m_reg <= '0; m_data <= '0; m_t <= 0;
    end else if (!m_busy) begin
      if (data_we) m_data <= data_wdata;
      if (ctl_we) begin
        m_phy <= ctl_phy; m_reg <= ctl_reg; m_wr <= ctl_write;
        if (ctl_start) begin m_busy <= 1'b1; m_t <= 0; end
      end
    end else if (m_t == FRAME_CLKS - 1) begin
      m_busy <= 1'b0;
      if (!m_wr) m_data <= phy_word;
    end else begin
      m_t <= m_t + 1;
    end
  end

  // emulated PHY: drives from its own bit count
  function automatic logic phy_level(int b);
    if (b == 47) return 1'b0;
    if (b >= 48 && b <= 63) return phy_word[63 - b];
    return 1'b1;
  endfunction
  assign mdio_i = (m_busy && !m_wr) ? phy_level(m_t / (2 * D)) : 1'b1;

  function automatic logic exp_bit(int b);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, m_wr ? 2'b01 : 2'b10, m_phy, m_reg, 2'b10, m_data};
    return f[63 - b];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int b;
      logic e_mdc;
      b = m_t / (2 * D);
      e_mdc = m_busy ? logic'((m_t / D) % 2) : 1'b0;
      chk(busy == m_busy, "R9", "busy", busy, m_busy);
      chk(mdc == e_mdc, m_busy ? "R2" : "R1", "mdc", mdc, e_mdc);
      chk(phy_q == m_phy && reg_q == m_reg && write_q == m_wr, m_busy ? "R10" : "R11",
          "fields", {phy_q, reg_q, write_q}, {m_phy, m_reg, m_wr});
      chk(data_q == m_data, m_busy ? "R10" : "R7", "data_q", data_q, m_data);
      if (!m_busy) chk(!mdio_oe, "R1", "idle oe", mdio_oe, 0);
      else if (!m_wr && b >= 46) chk(!mdio_oe, "R7", "read release", mdio_oe, 0);
      else begin
        string r;
        logic e;
        e = exp_bit(b);
        r = (b < 32) ? "R3" : (b < 36) ? "R4" : (b < 46) ? "R5" : "R6";
        chk(mdio_oe && mdio_o == e, r, "mdio", {mdio_oe, mdio_o}, {1'b1, e});
        if (prev_oe && mdio_oe && mdio_o != prev_o)
          chk(!mdc && b > 0 && (m_t % (2 * D)) == 0, "R8", "change edge", mdc, 0);
      end
      prev_o = mdio_o; prev_oe = mdio_oe;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic ctl(input logic [4:0] p, input logic [4:0] r, input logic w, input logic s);
    ctl_phy = p; ctl_reg = r; ctl_write = w; ctl_start = s; ctl_we = 1'b1;
    cyc(1);
    ctl_we = 1'b0; ctl_start = 1'b0;
  endtask

  task automatic dwr(input logic [15:0] v);
    data_wdata = v; data_we = 1'b1;
    cyc(1);
    data_we = 1'b0;
  endtask

  initial begin
    cyc(3);
    #2;
    chk(!busy && !mdc && !mdio_oe && data_q == 0 && phy_q == 0, "R1", "reset",
        {busy, mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    cyc(2);
    dwr(16'hA5C3);                     // R11
    ctl(5'h15, 5'h0A, 1'b1, 1'b0);     // R11 no start
    cyc(5);
    ctl(5'h15, 5'h0A, 1'b1, 1'b1);     // R2 write frame
    cyc(40);
    ctl(5'h03, 5'h1F, 1'b0, 1'b1);     // R10 ignored
    dwr(16'h1234);                     // R10 ignored
    cyc(FRAME_CLKS);
    phy_word = 16'hBEEF;
    ctl(5'h1F, 5'h00, 1'b0, 1'b1);     // R7 read
    cyc(100);
    dwr(16'h0F0F);                     // R10 ignored during read
    cyc(FRAME_CLKS);
    phy_word = 16'h8001;
    ctl(5'h00, 5'h11, 1'b0, 1'b1);     // R7 second read
    cyc(FRAME_CLKS + 4);
    dwr(16'h0000);
    ctl(5'h0A, 5'h15, 1'b1, 1'b1);     // R6 all-zero data
    cyc(FRAME_CLKS + 4);
    dwr(16'hFFFF);
    ctl(5'h1F, 5'h1F, 1'b1, 1'b1);     // R5 all-ones fields
    cyc(FRAME_CLKS + 4);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule